// File: doc/BRIEF.md
# Integer Overflow and Carry Flag Unit

This block keeps the fixed-point exception flags of a 32-bit integer pipeline: a sticky summary overflow bit, an overflow bit, a carry bit and an 8-bit byte count. Each cycle the execute stage presents an operation code, the two source operands, the result it already computed, an overflow-enable bit and a record bit. The unit derives the overflow and carry outcome for that operation, folds them into its state on the next clock edge, and, when the record bit is set, latches a 4-bit condition field that compares the result with zero.

The whole flag state can also be written as one 32-bit word and is always readable as one packed 32-bit word, so that move-to and move-from instructions need no extra decoding. The result datapaths are outside the block. The only exception is the signed 64-bit product that the multiply-low overflow rule needs, which the block forms itself.

Operation codes: 0 none, 1 add, 2 add carrying, 3 add extended, 4 subtract-from, 5 subtract-from carrying, 6 subtract-from extended, 7 subtract-from immediate, 8 signed divide, 9 unsigned divide, 10 multiply-low, 11 negate. For the subtract-from forms the result is b minus a.

Top module: `flag_unit`

## Requirements
- R1: A synchronous active-high reset clears SO, OV, CA, the byte count and the condition field, so the packed word reads 0 and cr0 reads 0.
- R2: For operation codes 1, 2 and 3 the new OV is bit 31 of (~(a ^ b) & (a ^ result)): it is set only when both operands have the same sign and the result sign differs.
- R3: For operation codes 4 to 7 the new OV follows the R2 rule with a replaced by ~a.
- R4: For code 8 the new OV is 1 when b is 0, or when a is 0x80000000 and b is 0xFFFFFFFF. For code 9 the new OV is 1 only when b is 0.
- R5: For code 10 the new OV is 1 when the upper 32 bits of the signed 64-bit product a*b differ from the sign extension of its lower 32 bits.
- R6: For code 11 the new OV is 1 exactly when a is 0x80000000.
- R7: Whenever OV is written, SO becomes old SO OR new OV. Arithmetic never clears SO.
- R8: OV and SO are written only when the overflow-enable input is 1 and the code is not 0. Otherwise both hold.
- R9: Carry rules. Code 2: CA = result <u a. Code 3: CA = (result <u a) or (old CA and result == a). Codes 5 and 7: CA = result <=u b. Code 6: CA = (result <u b) or (old CA and result == b).
- R10: For codes other than 2, 3, 5, 6 and 7, CA holds its value.
- R11: The packed word mf_data carries SO at bit 31, OV at bit 30, CA at bit 29 and the byte count at bits 7:0, with zeros in all other bits. A move-to (mt_we = 1) loads each field from the same bit positions of mt_data.
- R12: When rec_en is 1, cr0 becomes {LT, GT, EQ, SO} at bits 3..0. LT, GT and EQ come from the signed comparison of the result with zero, and SO is the value SO takes at that same edge. When rec_en is 0, cr0 holds.
- R13: When a move-to and an arithmetic flag update occur in the same cycle, the move-to alone sets SO, OV, CA and the byte count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | 4 | Operation code, encoded as listed above |
| opnd_a | input | 32 | First source operand |
| opnd_b | input | 32 | Second source operand |
| result | input | 32 | Result computed by the datapath |
| ov_en | input | 1 | Enables the OV and SO update |
| rec_en | input | 1 | Record bit that updates cr0 |
| mt_we | input | 1 | Move-to write strobe |
| mt_data | input | 32 | Move-to packed word |
| mf_data | output | 32 | Packed flag word |
| cr0 | output | 4 | Condition field {LT, GT, EQ, SO} |

## Verification
Every result is due one clock edge after its stimulus. Operands, strobes and move-to data are driven at a falling edge, the next rising edge registers the flags and cr0, and mf_data is a pure repack of those registers. The bench therefore samples both outputs at the falling edge that follows that single rising edge. Each table vector first presets the flags with a move-to one cycle earlier, so its expected packed word depends only on that vector. cr0 carries over from the most recent recorded vector, and the table's expected values follow that carry-over.

// File: rtl/flag_pkg.sv
package flag_pkg;
    localparam int XLEN   = 32;
    localparam int BCW    = 8;
    localparam int SO_POS = XLEN - 1;
    localparam int OV_POS = XLEN - 2;
    localparam int CA_POS = XLEN - 3;
    localparam int OPW    = 4;
    localparam int CRW    = 4;

    typedef enum logic [OPW-1:0] {
        OP_NONE  = 4'd0,
        OP_ADD   = 4'd1,
        OP_ADDC  = 4'd2,
        OP_ADDE  = 4'd3,
        OP_SUBF  = 4'd4,
        OP_SUBFC = 4'd5,
        OP_SUBFE = 4'd6,
        OP_SUBFI = 4'd7,
        OP_DIVW  = 4'd8,
        OP_DIVWU = 4'd9,
        OP_MULLW = 4'd10,
        OP_NEG   = 4'd11
    } flag_op_e;

    typedef struct packed {
        logic           so;
        logic           ov;
        logic           ca;
        logic [BCW-1:0] bc;
    } flag_state_t;
endpackage

// File: rtl/flag_ov_calc.sv
module flag_ov_calc
    import flag_pkg::*;
(
    input  logic [OPW-1:0]  op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic [XLEN-1:0] r,
    output logic            ov_val,
    output logic            ov_def
);
    localparam logic [XLEN-1:0] MIN_NEG = {1'b1, {(XLEN-1){1'b0}}};

    logic signed [2*XLEN-1:0] prod;
    logic [XLEN-1:0]          na;
    logic                     add_ov;
    logic                     sub_ov;
    logic                     b_zero;

    assign prod   = $signed(a) * $signed(b);
    assign na     = ~a;
    assign add_ov = ~(a[XLEN-1] ^ b[XLEN-1]) & (a[XLEN-1] ^ r[XLEN-1]);
    assign sub_ov = ~(na[XLEN-1] ^ b[XLEN-1]) & (na[XLEN-1] ^ r[XLEN-1]);
    assign b_zero = (b == '0);

    always_comb begin
        ov_val = 1'b0;
        ov_def = 1'b1;
        case (op)
            OP_ADD, OP_ADDC, OP_ADDE:             ov_val = add_ov;
            OP_SUBF, OP_SUBFC, OP_SUBFE, OP_SUBFI: ov_val = sub_ov;
            OP_DIVW:  ov_val = b_zero | ((a == MIN_NEG) & (b == '1));
            OP_DIVWU: ov_val = b_zero;
            OP_MULLW: ov_val = (prod[2*XLEN-1:XLEN] != {XLEN{prod[XLEN-1]}});
            OP_NEG:   ov_val = (a == MIN_NEG);
            default:  ov_def = 1'b0;
        endcase
    end
endmodule

// File: rtl/flag_ca_calc.sv
module flag_ca_calc
    import flag_pkg::*;
(
    input  logic [OPW-1:0]  op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic [XLEN-1:0] r,
    input  logic            ca_old,
    output logic            ca_val,
    output logic            ca_def
);
    logic r_lt_a;
    logic r_eq_a;
    logic r_lt_b;
    logic r_eq_b;

    assign r_lt_a = (r < a);
    assign r_eq_a = (r == a);
    assign r_lt_b = (r < b);
    assign r_eq_b = (r == b);

    always_comb begin
        ca_val = 1'b0;
        ca_def = 1'b1;
        case (op)
            OP_ADDC:           ca_val = r_lt_a;
            OP_ADDE:           ca_val = r_lt_a | (ca_old & r_eq_a);
            OP_SUBFC, OP_SUBFI: ca_val = r_lt_b | r_eq_b;
            OP_SUBFE:          ca_val = r_lt_b | (ca_old & r_eq_b);
            default:           ca_def = 1'b0;
        endcase
    end
endmodule

// File: rtl/flag_cr_calc.sv
module flag_cr_calc
    import flag_pkg::*;
(
    input  logic [XLEN-1:0] r,
    input  logic            so_new,
    output logic [CRW-1:0]  cr_val
);
    logic lt;
    logic eq;

    assign lt     = r[XLEN-1];
    assign eq     = (r == '0);
    assign cr_val = {lt, ~lt & ~eq, eq, so_new};
endmodule

// File: rtl/flag_unit.sv
module flag_unit
    import flag_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [3:0]      op_code,
    input  logic [31:0]     opnd_a,
    input  logic [31:0]     opnd_b,
    input  logic [31:0]     result,
    input  logic            ov_en,
    input  logic            rec_en,
    input  logic            mt_we,
    input  logic [31:0]     mt_data,
    output logic [31:0]     mf_data,
    output logic [3:0]      cr0
);
    flag_state_t    st_q;
    flag_state_t    st_d;
    logic [CRW-1:0] cr_q;
    logic [CRW-1:0] cr_d;
    logic           ov_val;
    logic           ov_def;
    logic           ca_val;
    logic           ca_def;
    logic           mt_unused;

    assign mt_unused = ^mt_data[CA_POS-1:BCW];

    flag_ov_calc u_ov (
        .op     (op_code),
        .a      (opnd_a),
        .b      (opnd_b),
        .r      (result),
        .ov_val (ov_val),
        .ov_def (ov_def)
    );

    flag_ca_calc u_ca (
        .op     (op_code),
        .a      (opnd_a),
        .b      (opnd_b),
        .r      (result),
        .ca_old (st_q.ca),
        .ca_val (ca_val),
        .ca_def (ca_def)
    );

    always_comb begin
        st_d = st_q;
        if (mt_we) begin
            st_d.so = mt_data[SO_POS];
            st_d.ov = mt_data[OV_POS];
            st_d.ca = mt_data[CA_POS];
            st_d.bc = mt_data[BCW-1:0];
        end else begin
            if (ov_en && ov_def) begin
                st_d.ov = ov_val;
                st_d.so = st_q.so | ov_val;
            end
            if (ca_def) begin
                st_d.ca = ca_val;
            end
        end
    end

    flag_cr_calc u_cr (
        .r      (result),
        .so_new (st_d.so),
        .cr_val (cr_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
            cr_q <= '0;
        end else begin
            st_q <= st_d;
            if (rec_en) begin
                cr_q <= cr_d;
            end
        end
    end

    assign mf_data = {st_q.so, st_q.ov, st_q.ca, {(CA_POS-BCW){1'b0}}, st_q.bc};
    assign cr0     = cr_q;
endmodule

// File: rtl/flag_unit_chk.sv
module flag_unit_chk
    import flag_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [3:0]  op_code,
    input logic [31:0] opnd_b,
    input logic        ov_en,
    input logic        rec_en,
    input logic        mt_we,
    input logic [31:0] mt_data,
    input logic [31:0] mf_data,
    input logic [3:0]  cr0
);
    logic carrying;
    assign carrying = (op_code == OP_ADDC) || (op_code == OP_ADDE) ||
                      (op_code == OP_SUBFC) || (op_code == OP_SUBFE) ||
                      (op_code == OP_SUBFI);

    AST_SO_STICKY: assert property (@(posedge clk) disable iff (rst)
        (!mt_we && mf_data[SO_POS]) |=> mf_data[SO_POS]); // R7

    AST_OV_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!mt_we && !ov_en) |=> ($stable(mf_data[OV_POS]) && $stable(mf_data[SO_POS]))); // R8

    AST_CA_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!mt_we && !carrying) |=> $stable(mf_data[CA_POS])); // R10

    AST_DIVU_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!mt_we && ov_en && op_code == OP_DIVWU && opnd_b == '0) |=> mf_data[OV_POS]); // R4

    AST_MOVE_TO: assert property (@(posedge clk) disable iff (rst)
        mt_we |=> (mf_data == {$past(mt_data[SO_POS:CA_POS]), {(CA_POS-BCW){1'b0}},
                               $past(mt_data[BCW-1:0])})); // R13

    AST_PACK_ZERO: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> (mf_data[CA_POS-1:BCW] == '0)); // R11

    AST_CR_ONE_REL: assert property (@(posedge clk) disable iff (rst)
        rec_en |=> ($countones(cr0[3:1]) == 1)); // R12

    AST_CR_SO: assert property (@(posedge clk) disable iff (rst)
        rec_en |=> (cr0[0] == mf_data[SO_POS])); // R12
endmodule

bind flag_unit flag_unit_chk chk_i (
    .clk     (clk),
    .rst     (rst),
    .op_code (op_code),
    .opnd_b  (opnd_b),
    .ov_en   (ov_en),
    .rec_en  (rec_en),
    .mt_we   (mt_we),
    .mt_data (mt_data),
    .mf_data (mf_data),
    .cr0     (cr0)
);

// File: tb/flag_unit_tb_top.sv
`timescale 1ns/1ps
module flag_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  op_code;
    logic [31:0] opnd_a, opnd_b, result, mt_data;
    logic        ov_en, rec_en, mt_we;
    logic [31:0] mf_data;
    logic [3:0]  cr0;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    flag_unit dut_i (
        .clk(clk), .rst(rst), .op_code(op_code), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .result(result), .ov_en(ov_en), .rec_en(rec_en), .mt_we(mt_we),
        .mt_data(mt_data), .mf_data(mf_data), .cr0(cr0)
    );

    typedef struct packed {
        logic [31:0] init;
        logic [3:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] r;
        logic        oe;
        logic        rec;
        logic [31:0] xer;
        logic [3:0]  cr;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0000, 4'd1,  32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000, 1'b1, 1'b1, 32'hC000_0000, 4'h9}, // R2
        '{32'h0000_0012, 4'd1,  32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 1'b1, 1'b1, 32'h0000_0012, 4'h2}, // R2
        '{32'h8000_0000, 4'd1,  32'h0000_0001, 32'h0000_0002, 32'h0000_0003, 1'b1, 1'b0, 32'h8000_0000, 4'h2}, // R7
        '{32'h0000_0000, 4'd4,  32'h0000_0001, 32'h8000_0000, 32'h7FFF_FFFF, 1'b1, 1'b1, 32'hC000_0000, 4'h5}, // R3
        '{32'h0000_0000, 4'd4,  32'h0000_0005, 32'h0000_0003, 32'hFFFF_FFFE, 1'b1, 1'b1, 32'h0000_0000, 4'h8}, // R3
        '{32'h0000_0000, 4'd8,  32'h8000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 1'b0, 32'hC000_0000, 4'h8}, // R4
        '{32'h0000_0000, 4'd8,  32'h0000_0005, 32'h0000_0000, 32'h0000_0000, 1'b1, 1'b0, 32'hC000_0000, 4'h8}, // R4
        '{32'h0000_0000, 4'd9,  32'h8000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 1'b0, 32'h0000_0000, 4'h8}, // R4
        '{32'h0000_0000, 4'd10, 32'h0001_0000, 32'h0001_0000, 32'h0000_0000, 1'b1, 1'b0, 32'hC000_0000, 4'h8}, // R5
        '{32'h0000_0000, 4'd10, 32'hFFFF_FFFF, 32'h0000_0005, 32'hFFFF_FFFB, 1'b1, 1'b0, 32'h0000_0000, 4'h8}, // R5
        '{32'h0000_0000, 4'd11, 32'h8000_0000, 32'h0000_0000, 32'h8000_0000, 1'b1, 1'b0, 32'hC000_0000, 4'h8}, // R6
        '{32'h0000_0000, 4'd1,  32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000, 1'b0, 1'b1, 32'h0000_0000, 4'h8}, // R8
        '{32'h0000_0000, 4'd2,  32'hFFFF_FFFF, 32'h0000_0002, 32'h0000_0001, 1'b0, 1'b0, 32'h2000_0000, 4'h8}, // R9
        '{32'h2000_0000, 4'd3,  32'h0000_0005, 32'hFFFF_FFFF, 32'h0000_0005, 1'b0, 1'b0, 32'h2000_0000, 4'h8}, // R9
        '{32'h0000_0000, 4'd3,  32'h0000_0005, 32'h0000_0000, 32'h0000_0005, 1'b0, 1'b0, 32'h0000_0000, 4'h8}, // R9
        '{32'h0000_0000, 4'd5,  32'h0000_0003, 32'h0000_0003, 32'h0000_0000, 1'b0, 1'b0, 32'h2000_0000, 4'h8}, // R9
        '{32'h2000_0000, 4'd6,  32'h0000_0000, 32'h0000_0007, 32'h0000_0007, 1'b0, 1'b0, 32'h2000_0000, 4'h8}, // R9
        '{32'h2000_0000, 4'd7,  32'h0000_0005, 32'h0000_0003, 32'hFFFF_FFFE, 1'b0, 1'b0, 32'h0000_0000, 4'h8}, // R9
        '{32'h2000_0000, 4'd1,  32'hFFFF_FFFF, 32'h0000_0002, 32'h0000_0001, 1'b0, 1'b0, 32'h2000_0000, 4'h8}, // R10
        '{32'hFFFF_FFFF, 4'd0,  32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0, 32'hE000_00FF, 4'h8}  // R11
    };

    function automatic string vreq(int i);
        case (i)
            0, 1:    return "R2";
            2:       return "R7";
            3, 4:    return "R3";
            5, 6, 7: return "R4";
            8, 9:    return "R5";
            10:      return "R6";
            11:      return "R8";
            18:      return "R10";
            19:      return "R11";
            default: return "R9";
        endcase
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        op_code = 4'd0; opnd_a = '0; opnd_b = '0; result = '0;
        ov_en = 1'b0; rec_en = 1'b0; mt_we = 1'b0; mt_data = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        idle();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "flags after reset", mf_data, 32'h0);
        check("R1", "cr0 after reset", {28'h0, cr0}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            idle();
            mt_we = 1'b1; mt_data = VECS[i].init;
            @(negedge clk);
            mt_we = 1'b0; mt_data = '0;
            op_code = VECS[i].op; opnd_a = VECS[i].a; opnd_b = VECS[i].b;
            result = VECS[i].r; ov_en = VECS[i].oe; rec_en = VECS[i].rec;
            @(negedge clk);
            idle();
            check(vreq(i), $sformatf("vector %0d flags", i), mf_data, VECS[i].xer);
            check(vreq(i), $sformatf("vector %0d cr0", i), {28'h0, cr0}, {28'h0, VECS[i].cr});
        end

        // R13: move-to wins over an overflowing add in the same cycle
        @(negedge clk);
        mt_we = 1'b1; mt_data = 32'h0000_0034;
        op_code = 4'd2; opnd_a = 32'h7FFF_FFFF; opnd_b = 32'h8000_0001; result = 32'h0000_0000;
        ov_en = 1'b1; rec_en = 1'b1;
        @(negedge clk);
        idle();
        check("R13", "move-to priority flags", mf_data, 32'h0000_0034);
        check("R12", "cr0 EQ with SO from move-to", {28'h0, cr0}, 32'h2);

        // R12: positive result records GT with sticky SO
        @(negedge clk);
        mt_we = 1'b1; mt_data = 32'h8000_0000;
        @(negedge clk);
        idle();
        op_code = 4'd1; opnd_a = 32'h1; opnd_b = 32'h1; result = 32'h2; rec_en = 1'b1;
        @(negedge clk);
        idle();
        check("R12", "cr0 GT with SO", {28'h0, cr0}, 32'h5);

        // R1: reset from a non-zero state
        @(negedge clk);
        mt_we = 1'b1; mt_data = 32'hE000_0077;
        @(negedge clk);
        idle();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1", "flags after second reset", mf_data, 32'h0);
        check("R1", "cr0 after second reset", {28'h0, cr0}, 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule